// File: doc/BRIEF.md
# Aliased Register File

This block holds sixteen 16-bit general-purpose registers. Software-visible operands reach them through several overlapping views of one shared storage array. A view can be a whole word, the upper or lower byte of a word, a 32-bit pair of neighbouring registers, or a 24-bit pointer. A pointer joins the low byte of a bank register with a full 16-bit address register. No view has storage of its own, so a write through any one view changes what every other view returns from the next cycle onward.

There are two combinational read ports and one synchronous write port. Each port takes a 3-bit view code and an 8-bit operand selector. The selector holds two packed 4-bit fields: the low nibble is the first operand and the high nibble is the second. A separate multiply-result input loads a 32-bit product into registers 0 and 1 in one cycle. The rest of the datapath decodes instructions and feeds the ports.

Top module: `aliased_regfile`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, every register reads as zero.
- R2: View code 0 (word) reads or writes the whole register whose index is selector bits 3:0, for any index from 0 to 15.
- R3: View code 1 (low byte) and view code 2 (high byte) read or write one byte of the register at selector bits 3:0. A byte write takes its value from data bits 7:0 and leaves the other byte of that register unchanged.
- R4: View code 3 (pair) uses selector bits 3:1 to pick the even register 2k and the odd register 2k+1. Register 2k is bits 31:16 and register 2k+1 is bits 15:0. A pair write overwrites both registers.
- R5: View code 4 (pointer) takes bank code = selector bits 2:0 (register 8+code) and address code = selector bits 6:4 (register code). It reads as {bank low byte, address register} in bits 23:0. A pointer write stores data bits 23:16 into the bank register's low byte, keeping its high byte, and stores data bits 15:0 into the address register.
- R6: Every view aliases the same storage. A write through one view is seen through all overlapping views, including other pointers that share a bank or address register.
- R7: Reads are combinational. A read in the same cycle as a write to overlapping storage returns the old value, and the new value is seen from the next cycle.
- R8: When the multiply-result enable is high, register 0 takes product bits 31:16 and register 1 takes product bits 15:0 at the clock edge.
- R9: When a normal write and a multiply-result write hit the same register in one cycle, the multiply result wins for registers 0 and 1. Parts of the normal write that fall on other registers still take effect.
- R10: View codes 5, 6 and 7 are invalid. A write with such a code changes nothing, and a read with such a code returns zero.
- R11: Read data narrower than 32 bits is zero-extended: bytes occupy bits 7:0, words bits 15:0 and pointers bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd0_view | input | 3 | View code of read port 0 |
| rd0_sel | input | 8 | Packed operand selector of read port 0 |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_view | input | 3 | View code of read port 1 |
| rd1_sel | input | 8 | Packed operand selector of read port 1 |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write port enable |
| wr_view | input | 3 | View code of the write port |
| wr_sel | input | 8 | Packed operand selector of the write port |
| wr_data | input | 32 | Write data, low-aligned for narrow views |
| mul_en | input | 1 | Multiply-result write enable |
| mul_data | input | 32 | 32-bit product for registers 0 and 1 |

## Verification
The assertions assume that every control and data input holds a known value on each clock edge once the internal reset has released. They also assume that no write is issued while the internal reset is still held, since such a write would be dropped without the properties knowing. The stimulus holds all inputs at zero through reset and for several cycles after it. From then on it drives every input at the falling edge, using seeded random values over all eight view codes and every selector value. Random operations are mixed with directed cases: byte merges, odd pair selectors, pointers that share a bank or address register, and collisions between the multiply port and the write port.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [2:0] {
    VIEW_WORD = 3'd0,
    VIEW_LO   = 3'd1,
    VIEW_HI   = 3'd2,
    VIEW_PAIR = 3'd3,
    VIEW_PTR  = 3'd4
  } view_e;

endpackage

// File: rtl/arf_rst_sync.sv
module arf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/arf_read_view.sv
module arf_read_view
  import arf_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int NREG      = 16,
  parameter int BANK_BASE = 8,
  localparam int IDX_W    = $clog2(NREG),
  localparam int BYTE_W   = REG_W / 2,
  localparam int PAIR_W   = 2 * REG_W
) (
  input  logic [NREG-1:0][REG_W-1:0] regs_i,
  input  logic [2:0]                 view_i,
  input  logic [2*IDX_W-1:0]         sel_i,
  output logic [PAIR_W-1:0]          data_o
);

  localparam int CODE_W = IDX_W - 1;

  logic [IDX_W-1:0] first_idx;
  logic [IDX_W-1:0] second_nib;
  logic [IDX_W-1:0] pair_even;
  logic [IDX_W-1:0] pair_odd;
  logic [IDX_W-1:0] bank_idx;
  logic [IDX_W-1:0] addr_idx;
  logic             unused_sel_msb;

  always_comb begin
    first_idx  = sel_i[IDX_W-1:0];
    second_nib = sel_i[2*IDX_W-1:IDX_W];
    pair_even  = {first_idx[IDX_W-1:1], 1'b0};
    pair_odd   = {first_idx[IDX_W-1:1], 1'b1};
    bank_idx   = IDX_W'(BANK_BASE) + IDX_W'(first_idx[CODE_W-1:0]);
    addr_idx   = IDX_W'(second_nib[CODE_W-1:0]);
  end

  assign unused_sel_msb = second_nib[IDX_W-1];

  always_comb begin
    data_o = '0;
    case (view_e'(view_i))
      VIEW_WORD: data_o = PAIR_W'(regs_i[first_idx]);
      VIEW_LO:   data_o = PAIR_W'(regs_i[first_idx][BYTE_W-1:0]);
      VIEW_HI:   data_o = PAIR_W'(regs_i[first_idx][REG_W-1:BYTE_W]);
      VIEW_PAIR: data_o = {regs_i[pair_even], regs_i[pair_odd]};
      VIEW_PTR:  data_o = PAIR_W'({regs_i[bank_idx][BYTE_W-1:0], regs_i[addr_idx]});
      default:   data_o = '0;
    endcase
  end

endmodule

// File: rtl/arf_write_merge.sv
module arf_write_merge
  import arf_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int NREG      = 16,
  parameter int BANK_BASE = 8,
  localparam int IDX_W    = $clog2(NREG),
  localparam int BYTE_W   = REG_W / 2,
  localparam int PAIR_W   = 2 * REG_W
) (
  input  logic [NREG-1:0][REG_W-1:0] regs_i,
  input  logic                       wr_en_i,
  input  logic [2:0]                 wr_view_i,
  input  logic [2*IDX_W-1:0]         wr_sel_i,
  input  logic [PAIR_W-1:0]          wr_data_i,
  input  logic                       mul_en_i,
  input  logic [PAIR_W-1:0]          mul_data_i,
  output logic [NREG-1:0]            we_o,
  output logic [NREG-1:0][REG_W-1:0] wd_o
);

  localparam int CODE_W = IDX_W - 1;

  logic [IDX_W-1:0] first_idx;
  logic [IDX_W-1:0] second_nib;
  logic [IDX_W-1:0] pair_even;
  logic [IDX_W-1:0] pair_odd;
  logic [IDX_W-1:0] bank_idx;
  logic [IDX_W-1:0] addr_idx;
  logic             unused_sel_msb;

  always_comb begin
    first_idx  = wr_sel_i[IDX_W-1:0];
    second_nib = wr_sel_i[2*IDX_W-1:IDX_W];
    pair_even  = {first_idx[IDX_W-1:1], 1'b0};
    pair_odd   = {first_idx[IDX_W-1:1], 1'b1};
    bank_idx   = IDX_W'(BANK_BASE) + IDX_W'(first_idx[CODE_W-1:0]);
    addr_idx   = IDX_W'(second_nib[CODE_W-1:0]);
  end

  assign unused_sel_msb = second_nib[IDX_W-1];

  // Next-state merge: normal port first, multiply port overrides after.
  always_comb begin
    we_o = '0;
    wd_o = regs_i;
    if (wr_en_i) begin
      case (view_e'(wr_view_i))
        VIEW_WORD: begin
          we_o[first_idx] = 1'b1;
          wd_o[first_idx] = wr_data_i[REG_W-1:0];
        end
        VIEW_LO: begin
          we_o[first_idx]              = 1'b1;
          wd_o[first_idx][BYTE_W-1:0]  = wr_data_i[BYTE_W-1:0];
        end
        VIEW_HI: begin
          we_o[first_idx]                  = 1'b1;
          wd_o[first_idx][REG_W-1:BYTE_W]  = wr_data_i[BYTE_W-1:0];
        end
        VIEW_PAIR: begin
          we_o[pair_even] = 1'b1;
          wd_o[pair_even] = wr_data_i[PAIR_W-1:REG_W];
          we_o[pair_odd]  = 1'b1;
          wd_o[pair_odd]  = wr_data_i[REG_W-1:0];
        end
        VIEW_PTR: begin
          we_o[bank_idx]             = 1'b1;
          wd_o[bank_idx][BYTE_W-1:0] = wr_data_i[REG_W+BYTE_W-1:REG_W];
          we_o[addr_idx]             = 1'b1;
          wd_o[addr_idx]             = wr_data_i[REG_W-1:0];
        end
        default: begin
          we_o = '0;
        end
      endcase
    end
    if (mul_en_i) begin
      we_o[0] = 1'b1;
      wd_o[0] = mul_data_i[PAIR_W-1:REG_W];
      we_o[1] = 1'b1;
      wd_o[1] = mul_data_i[REG_W-1:0];
    end
  end

endmodule

// File: rtl/arf_storage.sv
module arf_storage #(
  parameter int REG_W = 16,
  parameter int NREG  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            we_i,
  input  logic [NREG-1:0][REG_W-1:0] wd_i,
  output logic [NREG-1:0][REG_W-1:0] q_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    logic [REG_W-1:0] cell_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (we_i[g]) begin
        cell_q <= wd_i[g];
      end
    end

    assign q_o[g] = cell_q;
  end

endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
  parameter int REG_W      = 16,
  parameter int NREG       = 16,
  parameter int BANK_BASE  = 8,
  parameter int RST_STAGES = 2,
  localparam int IDX_W     = $clog2(NREG),
  localparam int SEL_W     = 2 * IDX_W,
  localparam int PAIR_W    = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rd0_view,
  input  logic [SEL_W-1:0]  rd0_sel,
  output logic [PAIR_W-1:0] rd0_data,
  input  logic [2:0]        rd1_view,
  input  logic [SEL_W-1:0]  rd1_sel,
  output logic [PAIR_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [2:0]        wr_view,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PAIR_W-1:0] wr_data,
  input  logic              mul_en,
  input  logic [PAIR_W-1:0] mul_data
);

  localparam int NRD = 2;

  logic                       rst_sync_n;
  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [NREG-1:0]            reg_we;
  logic [NREG-1:0][REG_W-1:0] reg_wd;
  logic [NRD-1:0][2:0]        rd_view;
  logic [NRD-1:0][SEL_W-1:0]  rd_sel;
  logic [NRD-1:0][PAIR_W-1:0] rd_data;

  arf_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  arf_write_merge #(.REG_W(REG_W), .NREG(NREG), .BANK_BASE(BANK_BASE)) u_merge (
    .regs_i     (regs_q),
    .wr_en_i    (wr_en),
    .wr_view_i  (wr_view),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .mul_en_i   (mul_en),
    .mul_data_i (mul_data),
    .we_o       (reg_we),
    .wd_o       (reg_wd)
  );

  arf_storage #(.REG_W(REG_W), .NREG(NREG)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we_i  (reg_we),
    .wd_i  (reg_wd),
    .q_o   (regs_q)
  );

  assign rd_view[0] = rd0_view;
  assign rd_sel[0]  = rd0_sel;
  assign rd_view[1] = rd1_view;
  assign rd_sel[1]  = rd1_sel;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    arf_read_view #(.REG_W(REG_W), .NREG(NREG), .BANK_BASE(BANK_BASE)) u_view (
      .regs_i (regs_q),
      .view_i (rd_view[p]),
      .sel_i  (rd_sel[p]),
      .data_o (rd_data[p])
    );
  end

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];

endmodule

// File: rtl/arf_checker.sv
module arf_checker
  import arf_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int BYTE_W = REG_W / 2,
  localparam int PAIR_W = 2 * REG_W
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic [NREG-1:0][REG_W-1:0] regs,
  input logic                       wr_en,
  input logic [2:0]                 wr_view,
  input logic [2*IDX_W-1:0]         wr_sel,
  input logic [PAIR_W-1:0]          wr_data,
  input logic                       mul_en,
  input logic [PAIR_W-1:0]          mul_data,
  input logic [2:0]                 rd0_view,
  input logic [2*IDX_W-1:0]         rd0_sel,
  input logic [PAIR_W-1:0]          rd0_data
);

  logic [IDX_W-1:0] w_idx;
  logic [IDX_W-1:0] w_even;
  logic             mul_hits_w;
  logic             unused_chk;

  assign w_idx      = wr_sel[IDX_W-1:0];
  assign w_even     = {w_idx[IDX_W-1:1], 1'b0};
  assign mul_hits_w = mul_en && (w_idx[IDX_W-1:1] == '0);
  assign unused_chk = ^{wr_sel[2*IDX_W-1:IDX_W], rd0_sel[2*IDX_W-1:IDX_W]};

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (regs == '0));

  p_word_readback_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_view == VIEW_WORD && !mul_hits_w)
    |=> (!(rd0_view == VIEW_WORD && rd0_sel[IDX_W-1:0] == $past(w_idx))
         || rd0_data == PAIR_W'($past(wr_data[REG_W-1:0]))));

  p_lo_byte_keep_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_view == VIEW_LO && !mul_hits_w)
    |=> (regs[$past(w_idx)][REG_W-1:BYTE_W] == $past(regs[w_idx][REG_W-1:BYTE_W])
         && regs[$past(w_idx)][BYTE_W-1:0] == $past(wr_data[BYTE_W-1:0])));

  p_pair_split_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_view == VIEW_PAIR && !mul_hits_w)
    |=> (regs[$past(w_even)] == $past(wr_data[PAIR_W-1:REG_W])
         && regs[$past(w_even) + 1'b1] == $past(wr_data[REG_W-1:0])));

  p_mul_load_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mul_en |=> (regs[0] == $past(mul_data[PAIR_W-1:REG_W])
                && regs[1] == $past(mul_data[REG_W-1:0])));

  p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((!wr_en || wr_view > VIEW_PTR) && !mul_en) |=> $stable(regs));

endmodule

bind aliased_regfile arf_checker #(.REG_W(REG_W), .NREG(NREG)) u_arf_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .regs       (regs_q),
  .wr_en      (wr_en),
  .wr_view    (wr_view),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .mul_en     (mul_en),
  .mul_data   (mul_data),
  .rd0_view   (rd0_view),
  .rd0_sel    (rd0_sel),
  .rd0_data   (rd0_data)
);

// File: tb/test_aliased_regfile.sv
module test_aliased_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk;
  logic        rst_n;
  logic [2:0]  rd0_view, rd1_view, wr_view;
  logic [7:0]  rd0_sel, rd1_sel, wr_sel;
  logic [31:0] rd0_data, rd1_data, wr_data, mul_data;
  logic        wr_en, mul_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mdl [16];

  aliased_regfile i_aliased_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd0_view(rd0_view), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
    .rd1_view(rd1_view), .rd1_sel(rd1_sel), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_view(wr_view), .wr_sel(wr_sel), .wr_data(wr_data),
    .mul_en(mul_en), .mul_data(mul_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [2:0] v, input logic [7:0] s);
    logic [3:0] i;
    i = s[3:0];
    case (v)
      3'd0: return {16'h0, mdl[i]};
      3'd1: return {24'h0, mdl[i][7:0]};
      3'd2: return {24'h0, mdl[i][15:8]};
      3'd3: return {mdl[{i[3:1], 1'b0}], mdl[{i[3:1], 1'b1}]};
      3'd4: return {8'h0, mdl[{1'b1, s[2:0]}][7:0], mdl[{1'b0, s[6:4]}]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic mdl_update(input logic we, input logic [2:0] v, input logic [7:0] s,
                            input logic [31:0] d, input logic me, input logic [31:0] md);
    logic [3:0] i;
    i = s[3:0];
    if (we) begin
      case (v)
        3'd0: mdl[i] = d[15:0];
        3'd1: mdl[i][7:0] = d[7:0];
        3'd2: mdl[i][15:8] = d[7:0];
        3'd3: begin
          mdl[{i[3:1], 1'b0}] = d[31:16];
          mdl[{i[3:1], 1'b1}] = d[15:0];
        end
        3'd4: begin
          mdl[{1'b1, s[2:0]}][7:0] = d[23:16];
          mdl[{1'b0, s[6:4]}] = d[15:0];
        end
        default: ;
      endcase
    end
    if (me) begin
      mdl[0] = md[31:16];
      mdl[1] = md[15:0];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, check reads against the model, clock, update model.
  task automatic cyc(input string req,
                     input logic [2:0] v0, input logic [7:0] s0,
                     input logic [2:0] v1, input logic [7:0] s1,
                     input logic we, input logic [2:0] wv, input logic [7:0] ws,
                     input logic [31:0] wd, input logic me, input logic [31:0] md);
    rd0_view = v0; rd0_sel = s0; rd1_view = v1; rd1_sel = s1;
    wr_en = we; wr_view = wv; wr_sel = ws; wr_data = wd;
    mul_en = me; mul_data = md;
    #1;
    chk(req, rd0_data, exp_read(v0, s0));
    chk(req, rd1_data, exp_read(v1, s1));
    @(posedge clk);
    mdl_update(we, wv, ws, wd, me, md);
    @(negedge clk);
    wr_en = 1'b0; mul_en = 1'b0;
  endtask

  // Read-only check against a constant worked out from the requirements.
  task automatic peek(input string req, input logic [2:0] v, input logic [7:0] s,
                      input logic [31:0] exp);
    wr_en = 1'b0; mul_en = 1'b0;
    rd0_view = v; rd0_sel = s;
    #1;
    chk(req, rd0_data, exp);
  endtask

  task automatic wr(input logic [2:0] v, input logic [7:0] s, input logic [31:0] d);
    cyc("R7", 3'd0, 8'h00, 3'd0, 8'h01, 1'b1, v, s, d, 1'b0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    for (int k = 0; k < 16; k++) mdl[k] = 16'h0;
    rst_n = 1'b0;
    rd0_view = 3'd0; rd0_sel = 8'h0; rd1_view = 3'd0; rd1_sel = 8'h0;
    wr_en = 1'b0; wr_view = 3'd0; wr_sel = 8'h0; wr_data = 32'h0;
    mul_en = 1'b0; mul_data = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 16; k++) peek("R1 in reset", 3'd0, 8'(k), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) peek("R1 after release", 3'd3, 8'(k), 32'h0);

    // R2 word view, R11 zero extension, R3 byte views
    wr(3'd0, 8'h05, 32'hFFFF_BEEF);
    peek("R2 word", 3'd0, 8'h05, 32'h0000_BEEF);
    wr(3'd0, 8'h0F, 32'h0000_7A7A);
    peek("R2 top index", 3'd0, 8'h0F, 32'h0000_7A7A);
    peek("R11 low byte", 3'd1, 8'h05, 32'h0000_00EF);
    peek("R11 high byte", 3'd2, 8'h05, 32'h0000_00BE);
    wr(3'd2, 8'h05, 32'h0000_0012);
    peek("R3 high byte keeps low", 3'd0, 8'h05, 32'h0000_12EF);
    wr(3'd1, 8'h05, 32'hFFFF_FF34);
    peek("R3 low byte keeps high", 3'd0, 8'h05, 32'h0000_1234);

    // R4 pair view, odd selector folds to even base
    wr(3'd3, 8'h05, 32'hCAFE_F00D);
    peek("R4 even half", 3'd0, 8'h04, 32'h0000_CAFE);
    peek("R4 odd half", 3'd0, 8'h05, 32'h0000_F00D);
    peek("R4 pair read", 3'd3, 8'h04, 32'hCAFE_F00D);

    // R5 pointer view; bank code 2 -> reg 10, address code 3 -> reg 3
    wr(3'd0, 8'h0A, 32'h0000_55CC);
    wr(3'd4, 8'h32, 32'hFFAB_1234);
    peek("R5 pointer read", 3'd4, 8'h32, 32'h00AB_1234);
    peek("R5 bank high byte kept", 3'd0, 8'h0A, 32'h0000_55AB);
    peek("R6 shared bank", 3'd4, 8'h72, 32'h00AB_0000);
    wr(3'd1, 8'h03, 32'h0000_0099);
    peek("R6 shared address", 3'd4, 8'h35, 32'h0000_1299);
    wr(3'd2, 8'h0A, 32'h0000_0077);
    peek("R6 bank high byte write", 3'd4, 8'h32, 32'h00AB_1299);

    // R7 same-cycle read returns old value
    cyc("R7 same cycle", 3'd0, 8'h03, 3'd4, 8'h32, 1'b1, 3'd0, 8'h03, 32'h0000_4444, 1'b0, 32'h0);
    peek("R7 next cycle", 3'd0, 8'h03, 32'h0000_4444);

    // R8 multiply port, R9 priority
    cyc("R8", 3'd0, 8'h00, 3'd0, 8'h01, 1'b0, 3'd0, 8'h00, 32'h0, 1'b1, 32'h1122_3344);
    peek("R8 pair", 3'd3, 8'h01, 32'h1122_3344);
    cyc("R9", 3'd0, 8'h00, 3'd0, 8'h01, 1'b1, 3'd3, 8'h00, 32'hDEAD_BEEF, 1'b1, 32'h5566_7788);
    peek("R9 mul beats pair", 3'd3, 8'h00, 32'h5566_7788);
    cyc("R9", 3'd0, 8'h00, 3'd0, 8'h01, 1'b1, 3'd4, 8'h10, 32'h00C3_ABCD, 1'b1, 32'h0102_0304);
    peek("R9 addr reg from mul", 3'd0, 8'h01, 32'h0000_0304);
    peek("R9 bank part kept", 3'd1, 8'h08, 32'h0000_00C3);

    // R10 invalid view codes
    for (int v = 5; v < 8; v++) begin
      wr(3'(v), 8'h05, 32'hFFFF_FFFF);
      peek("R10 write ignored", 3'd3, 8'h04, 32'hCAFE_F00D);
      peek("R10 read zero", 3'(v), 8'h05, 32'h0);
    end

    // Random mix checked against the model (R2..R11)
    for (int n = 0; n < N_RANDOM; n++) begin
      cyc("R6 random",
          3'($urandom % 8), 8'($urandom), 3'($urandom % 8), 8'($urandom),
          1'($urandom % 4 != 0), 3'($urandom % 8), 8'($urandom), $urandom,
          1'($urandom % 8 == 0), $urandom);
    end
    for (int k = 0; k < 16; k++) peek("R2 final sweep", 3'd0, 8'(k), {16'h0, mdl[k]});

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule